// File: doc/BRIEF.md
# Program Status Word Generator

This block builds the status word that a one-time-programmable memory returns on its data bus while an internal program operation runs, or after one has failed. While a program operation runs, every bus read returns this word, whatever the address. The read multiplexer uses the select output to put the word on the bus in place of array data. Once the operation finishes cleanly, the select drops and array reads resume. After a failure the select stays high until a reset command clears the error.

The status byte gives polling software three ways to detect completion. The top bit is the inverse of bit 7 of the word being written, so it differs from the written data until the array returns true data. A second bit flips once per read access while status is shown. The remaining bits are an error flag, a programming-voltage failure flag and a ready flag for multi-word programming. The upper byte of the bus word is zero.

Top module: `pgm_status_gen`

## Requirements
- R1: `status_sel` is 1 whenever `busy` is 1 or the error flag is set, and 0 otherwise. While it is 0, all of `status_o` is 0.
- R2: While `status_sel` is 1, `status_o[7]` equals the inverse of `prog_d7`.
- R3: `status_o[6]` shows a toggle bit. The bit inverts at each clock edge where the read strobe has risen (`rd_strb` is 1 and was 0 at the previous edge) and `status_sel` is 1. It holds on every other edge, including strobes taken while `status_sel` is 0. An `op_start` pulse clears it to 0, and the clear takes priority over the inversion.
- R4: `status_o[5]` is the error flag. It is set at the edge after `prog_fail` or `vpp_fail` is 1 while `busy` is 1. It stays set until `clear_err` is 1 while `busy` is 0.
- R5: `status_o[4]` is the voltage-failure flag. It is set at the edge after `vpp_fail` is 1 while `busy` is 1, and whenever it is set the error flag is also set. `op_start` or an accepted `clear_err` clears it, and a set in the same cycle takes priority.
- R6: While `status_sel` is 1, `status_o[0]` is 0 when `mw_ready` is 1 (the controller is waiting for the next word) and 1 when `mw_ready` is 0.
- R7: Bits 3, 2 and 1 of `status_o`, and bits `DATA_W-1` down to 8, are always 0.
- R8: After reset, the toggle bit, the error flag and the voltage flag are all 0, and `status_sel` is 0 while `busy` is 0.
- R9: `clear_err` has no effect while `busy` is 1. The error flag stays set and the block keeps selecting status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse at the start of a program operation |
| busy | input | 1 | Program operation in progress |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| prog_fail | input | 1 | Controller reports a failed write |
| vpp_fail | input | 1 | Programming voltage dropped below its high level |
| mw_ready | input | 1 | Multi-word controller is waiting for the next word |
| clear_err | input | 1 | Reset command is being accepted |
| rd_strb | input | 1 | Bus read access strobe, level |
| status_o | output | DATA_W | Status word for the read multiplexer |
| status_sel | output | 1 | Show status instead of array data |

## Verification
The toggle bit is the hardest state to confirm from the ports. Its value is invisible while `status_sel` is 0, so it is hard to show that a read strobe in array-read mode leaves it unchanged. To reach this case, the stimulus first sets the toggle bit to 1 with a read. It then drops `busy`, issues a strobe, and raises `busy` again without an `op_start` pulse, which brings the held value back onto the bus. A second hard case is a failed operation followed by a reset command while `busy` is still high. To cover it, the bench holds `busy` across `clear_err` and checks that the error flag and the select both survive.

// File: rtl/pss_pkg.sv
package pss_pkg;
   localparam int STAT_W  = 8;
   localparam int B_POLL  = 7;
   localparam int B_TGL   = 6;
   localparam int B_ERR   = 5;
   localparam int B_VPP   = 4;
   localparam int B_RDY   = 0;
endpackage

// File: rtl/pss_edge.sv
module pss_edge #(
   parameter bit ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   generate
      if (ON_RISE) begin : g_rise
         assign pulse = lvl & ~lvl_q;
      end else begin : g_fall
         assign pulse = ~lvl & lvl_q;
      end
   endgenerate
endmodule

// File: rtl/pss_toggle.sv
module pss_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic tgl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tgl <= 1'b0;
      else if (clr) tgl <= 1'b0;
      else if (adv) tgl <= ~tgl;
   end

   // R3: a start pulse always leaves the toggle at zero
   p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tgl);
endmodule

// File: rtl/pss_flags.sv
module pss_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic prog_fail,
   input  logic vpp_fail,
   input  logic clear_err,
   input  logic op_start,
   output logic err,
   output logic vpp
);
   logic err_set, vpp_set, clr_ok;

   assign err_set = busy & (prog_fail | vpp_fail);
   assign vpp_set = busy & vpp_fail;
   assign clr_ok  = clear_err & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b0;
      else if (err_set) err <= 1'b1;
      else if (clr_ok)  err <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   vpp <= 1'b0;
      else if (vpp_set)             vpp <= 1'b1;
      else if (clr_ok || op_start)  vpp <= 1'b0;
   end

   // R4 / R9: error stays until a reset command taken outside an operation
   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(clear_err && !busy)) |=> err);
   p_clr_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err && busy) |=> err);
   // R5: a voltage failure is always also an error
   p_vpp_has_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vpp |-> err);
endmodule

// File: rtl/pgm_status_gen.sv
module pgm_status_gen #(
   parameter int DATA_W  = 16,
   parameter bit ADV_ON_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              busy,
   input  logic              prog_d7,
   input  logic              prog_fail,
   input  logic              vpp_fail,
   input  logic              mw_ready,
   input  logic              clear_err,
   input  logic              rd_strb,
   output logic [DATA_W-1:0] status_o,
   output logic              status_sel
);
   import pss_pkg::*;

   localparam int HI_W = DATA_W - STAT_W;

   generate
      if (DATA_W < STAT_W) begin : g_bad_w
         $error("DATA_W must be at least the status byte width");
      end
   endgenerate

   logic rd_evt, tgl, err, vpp;
   logic [STAT_W-1:0] stat_b;

   pss_edge #(.ON_RISE(ADV_ON_RISE)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(rd_strb), .pulse(rd_evt));

   pss_flags u_flags (
      .clk(clk), .rst_n(rst_n), .busy(busy), .prog_fail(prog_fail),
      .vpp_fail(vpp_fail), .clear_err(clear_err), .op_start(op_start),
      .err(err), .vpp(vpp));

   assign status_sel = busy | err;

   pss_toggle u_tgl (
      .clk(clk), .rst_n(rst_n), .clr(op_start),
      .adv(rd_evt & status_sel), .tgl(tgl));

   always_comb begin
      stat_b         = '0;
      stat_b[B_POLL] = ~prog_d7;
      stat_b[B_TGL]  = tgl;
      stat_b[B_ERR]  = err;
      stat_b[B_VPP]  = vpp;
      stat_b[B_RDY]  = ~mw_ready;
   end

   generate
      if (HI_W > 0) begin : g_wide
         assign status_o = status_sel ? {{HI_W{1'b0}}, stat_b} : '0;
      end else begin : g_narrow
         assign status_o = status_sel ? stat_b : '0;
      end
   endgenerate

   // R1: nothing leaks onto the bus in array-read mode
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !status_sel |-> (status_o == '0));
   // R2: polling bit differs from the written bit while status is shown
   p_poll_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status_sel |-> (status_o[B_POLL] != prog_d7));
   // R7: constant-zero fields
   p_zero_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[3:1] == 3'b000 && (status_o >> STAT_W) == '0);

   generate
      if (ADV_ON_RISE) begin : g_a_rise
         // R3: one step per access edge while status is shown
         p_tgl_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rd_strb) && status_sel && !op_start) |=> (tgl != $past(tgl)));
         p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!($rose(rd_strb) && status_sel) && !op_start) |=> $stable(tgl));
      end else begin : g_a_fall
         p_tgl_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(rd_strb) && status_sel && !op_start) |=> (tgl != $past(tgl)));
         p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!($fell(rd_strb) && status_sel) && !op_start) |=> $stable(tgl));
      end
   endgenerate
endmodule

// File: tb/pgm_status_gen_tb.sv
module pgm_status_gen_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_start = 0, busy = 0, prog_d7 = 0, prog_fail = 0, vpp_fail = 0;
   logic mw_ready = 0, clear_err = 0, rd_strb = 0;
   logic [15:0] status_o;
   logic status_sel;
   int n_cmp = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   pgm_status_gen u_dut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .busy(busy),
      .prog_d7(prog_d7), .prog_fail(prog_fail), .vpp_fail(vpp_fail),
      .mw_ready(mw_ready), .clear_err(clear_err), .rd_strb(rd_strb),
      .status_o(status_o), .status_sel(status_sel));

   // vector: {busy, prog_d7, mw_ready, exp_sel, exp_status[15:0]}
   localparam logic [19:0] VEC [6] = '{
      {1'b1, 1'b0, 1'b0, 1'b1, 16'h0081},
      {1'b1, 1'b1, 1'b1, 1'b1, 16'h0000},
      {1'b1, 1'b0, 1'b1, 1'b1, 16'h0080},
      {1'b1, 1'b1, 1'b0, 1'b1, 16'h0001},
      {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
      {1'b0, 1'b1, 1'b1, 1'b0, 16'h0000}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic read_acc();
      rd_strb = 1'b1; step();
      rd_strb = 1'b0; step();
   endtask

   task automatic start_op();
      op_start = 1'b1; busy = 1'b1; step();
      op_start = 1'b0;
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 sel", {15'b0, status_sel}, 16'h0);
      chk("R8 word", status_o, 16'h0);
      rst_n = 1'b1; step();
      busy = 1'b1; #1;
      chk("R8 toggle/flags zero", status_o & 16'h0070, 16'h0);
      busy = 1'b0; step();

      start_op();
      // R1 R2 R6 R7 table walk
      for (int i = 0; i < 6; i++) begin
         busy = VEC[i][19]; prog_d7 = VEC[i][18]; mw_ready = VEC[i][17];
         #1;
         chk("R1 sel", {15'b0, status_sel}, {15'b0, VEC[i][16]});
         chk("R2/R6/R7 word", status_o, VEC[i][15:0]);
         step();
      end

      // R3: toggle sequence
      prog_d7 = 1'b1; mw_ready = 1'b1;
      start_op();
      chk("R3 start zero", status_o, 16'h0000);
      read_acc(); chk("R3 first read", status_o, 16'h0040);
      read_acc(); chk("R3 second read", status_o, 16'h0000);
      read_acc(); chk("R3 third read", status_o, 16'h0040);
      // R3: strobe in read mode does not advance
      busy = 1'b0; step();
      read_acc();
      busy = 1'b1; #1;
      chk("R3 idle strobe held", status_o, 16'h0040);
      // R3: op_start clears
      start_op(); #1;
      chk("R3 op_start clears", status_o, 16'h0000);

      // R4 R9: error sticky, clear ignored while busy
      prog_fail = 1'b1; step(); prog_fail = 1'b0;
      chk("R4 err set", status_o, 16'h0020);
      clear_err = 1'b1; step(); clear_err = 1'b0;
      chk("R9 clear while busy", status_o, 16'h0020);
      busy = 1'b0; step();
      chk("R4 err holds after busy", {15'b0, status_sel}, 16'h1);
      read_acc();
      chk("R3 toggles in error", status_o, 16'h0060);
      clear_err = 1'b1; step(); clear_err = 1'b0;
      chk("R4 err cleared sel", {15'b0, status_sel}, 16'h0);
      chk("R4 err cleared word", status_o, 16'h0);

      // R5: voltage failure
      start_op();
      vpp_fail = 1'b1; step(); vpp_fail = 1'b0;
      chk("R5 vpp set", status_o, 16'h0030);
      start_op(); #1;
      chk("R5 op_start clears vpp", status_o, 16'h0020);
      busy = 1'b0; clear_err = 1'b1; step(); clear_err = 1'b0;
      chk("R5 all clear", status_o, 16'h0000);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule